// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with Y Register

This unit performs 32-bit integer multiplication and division, signed or unsigned, for an integer pipeline. It works one bit per cycle. Its own Y register holds the upper half of every 64-bit quantity it touches. A multiply puts the low word of the product on `result` and leaves the high word in Y. A divide uses Y as the high word of a 64-bit dividend and `opa` as its low word, then divides by `opb`. The quotient saturates when it does not fit in 32 bits. A single multiply-step operation adds one conditional partial product, so software can build a multiply from a chain of steps.

A request is made by pulsing `start` with an operation code and operands while the unit is idle. The controller is a five-state machine:
- **IDLE** accepts a request. A multiply goes to **MUL_RUN**. A divide with a nonzero divisor goes to **DIV_RUN**. A multiply-step, or a divide by zero, goes straight to **DONE**.
- **MUL_RUN** spends W cycles, then moves to **FIXUP**.
- **DIV_RUN** spends 2W cycles, then moves to **FIXUP**.
- **FIXUP** applies the sign and saturation, writes `result` and Y, and moves to **DONE**.
- **DONE** raises `done` for one cycle and returns to **IDLE**.

Software can write Y through a separate port while the unit is idle. Y is always visible on `y_q`.

Top module: `mdu_y_unit`

## Requirements
- R1: After reset, `busy`, `done`, `ovf` and `dz` are low, and `result` and `y_q` are zero.
- R2: The `op` encodings are 0 unsigned multiply, 1 signed multiply, 2 unsigned divide, 3 signed divide, 4 multiply-step. A `start` is accepted only in IDLE with `op` between 0 and 4. A `start` while busy, or with `op` 5 to 7, has no effect on any output.
- R3: Count the cycle in which `start` is accepted as cycle 0. Then `done` is high in exactly one cycle:
  - cycle 1 for a multiply-step or a zero-divisor divide;
  - cycle W+2 for a multiply;
  - cycle 2W+2 for a divide.
  `busy` is high from cycle 1 through the `done` cycle and low after it.
- R4: An unsigned multiply forms the 64-bit product of `opa` and `opb`. It puts bits 31:0 on `result` and bits 63:32 in Y, both visible in the `done` cycle.
- R5: A signed multiply does the same with both operands read as two's complement, giving a two's complement 64-bit product.
- R6: An unsigned divide returns the quotient of {Y, `opa`} divided by `opb`, truncated. Y is left unchanged.
- R7: A signed divide reads {Y, `opa`} and `opb` as two's complement and truncates the quotient toward zero. Y is left unchanged.
- R8: If an unsigned quotient exceeds 0xFFFFFFFF, `result` is 0xFFFFFFFF and `ovf` is high in the `done` cycle.
- R9: If a signed quotient exceeds 0x7FFFFFFF, `result` is 0x7FFFFFFF. If it is below -2^31, `result` is 0x80000000. In both cases `ovf` is high in the `done` cycle.
- R10: A divide with `opb` zero gives `dz` high, `ovf` low and `result` zero in the `done` cycle, and leaves Y unchanged.
- R11: Multiply-step works as follows:
  - Let T be {`flag_n` XOR `flag_v`, `opa[31:1]`}.
  - `result` is T + `opb` when Y bit 0 is 1, and T otherwise.
  - Y becomes {`opa[0]`, Y[31:1]}.
- R12: When `y_wr_en` is high, the unit is idle and `start` is low, Y takes `y_wr_data` at the next edge. In any other case `y_wr_en` is ignored. `y_q` always shows Y.
- R13: `result` keeps its value from one `done` to the next. Y does not change during MUL_RUN or DIV_RUN. `ovf` and `dz` are low outside the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe |
| op | input | 3 | Operation code |
| opa | input | W | First operand / low dividend word |
| opb | input | W | Second operand / divisor |
| flag_n | input | 1 | Negative flag for multiply-step |
| flag_v | input | 1 | Overflow flag for multiply-step |
| y_wr_en | input | 1 | Direct Y write enable |
| y_wr_data | input | W | Direct Y write value |
| busy | output | 1 | Unit occupied |
| done | output | 1 | One-cycle completion pulse |
| result | output | W | Result word |
| ovf | output | 1 | Quotient saturated |
| dz | output | 1 | Divisor was zero |
| y_q | output | W | Current Y register |

## Verification
The bench builds the unit at its default width, W = 32. At that width the reference model can use native 64-bit integer arithmetic for products and dividends. This covers the exact boundary words 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF, and 64-bit dividends whose quotients sit one step on either side of the saturation limits. At 32 bits a divide holds the unit busy for 66 cycles. That window is long enough to test stray `start` pulses and Y writes made mid-operation.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    typedef enum logic [2:0] {
        OP_UMUL  = 3'd0,
        OP_SMUL  = 3'd1,
        OP_UDIV  = 3'd2,
        OP_SDIV  = 3'd3,
        OP_MSTEP = 3'd4
    } mdu_op_e;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_MULRUN = 3'd1,
        S_DIVRUN = 3'd2,
        S_FIXUP  = 3'd3,
        S_DONE   = 3'd4
    } mdu_state_e;

    function automatic logic op_is_div(input logic [2:0] code);
        return (code == OP_UDIV) || (code == OP_SDIV);
    endfunction

    function automatic logic op_is_mul(input logic [2:0] code);
        return (code == OP_UMUL) || (code == OP_SMUL);
    endfunction

    function automatic logic op_is_legal(input logic [2:0] code);
        return code <= OP_MSTEP;
    endfunction

endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
    import mdu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [2:0] op,
    input  logic       div_zero,
    output mdu_state_e state,
    output logic       busy,
    output logic       done,
    output logic       accept,
    output logic       mul_step,
    output logic       div_step,
    output logic       fix_en
);

    localparam int CW = $clog2(2 * W) + 1;
    localparam logic [CW-1:0] MUL_LAST = CW'(W - 1);
    localparam logic [CW-1:0] DIV_LAST = CW'(2 * W - 1);

    mdu_state_e    nxt;
    logic [CW-1:0] cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // iteration counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state == S_MULRUN || state == S_DIVRUN) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (start && op_is_legal(op)) begin
                    if (op_is_mul(op)) begin
                        nxt = S_MULRUN;
                    end else if (op_is_div(op) && !div_zero) begin
                        nxt = S_DIVRUN;
                    end else begin
                        nxt = S_DONE;
                    end
                end
            end
            S_MULRUN: if (cnt_q == MUL_LAST) nxt = S_FIXUP;
            S_DIVRUN: if (cnt_q == DIV_LAST) nxt = S_FIXUP;
            S_FIXUP:  nxt = S_DONE;
            S_DONE:   nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy     = 1'b1;
        done     = 1'b0;
        accept   = 1'b0;
        mul_step = 1'b0;
        div_step = 1'b0;
        fix_en   = 1'b0;
        unique case (state)
            S_IDLE: begin
                busy   = 1'b0;
                accept = start && op_is_legal(op);
            end
            S_MULRUN: mul_step = 1'b1;
            S_DIVRUN: div_step = 1'b1;
            S_FIXUP:  fix_en   = 1'b1;
            S_DONE:   done     = 1'b1;
            default:  busy     = 1'b0;
        endcase
    end

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R3
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R3
    mul_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MULRUN) |-> (cnt_q <= MUL_LAST));

endmodule

// File: rtl/mdu_mul_core.sv
module mdu_mul_core #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   a_mag,
    input  logic [W-1:0]   b_mag,
    output logic [2*W-1:0] prod
);

    localparam int W2 = 2 * W;

    logic [W2-1:0] acc_q;
    logic [W-1:0]  mcand_q;
    logic [W:0]    sum;

    always_comb begin
        if (acc_q[0]) begin
            sum = {1'b0, acc_q[W2-1:W]} + {1'b0, mcand_q};
        end else begin
            sum = {1'b0, acc_q[W2-1:W]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            mcand_q <= '0;
        end else if (load) begin
            acc_q   <= {{W{1'b0}}, b_mag};
            mcand_q <= a_mag;
        end else if (step) begin
            acc_q   <= {sum, acc_q[W-1:1]};
        end
    end

    assign prod = acc_q;

endmodule

// File: rtl/mdu_div_core.sv
module mdu_div_core #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [2*W-1:0] dvd_mag,
    input  logic [W-1:0]   dvs_mag,
    output logic [2*W-1:0] quo
);

    localparam int W2 = 2 * W;

    logic [W:0]    rem_q;
    logic [W2-1:0] q_q;
    logic [W-1:0]  dvs_q;
    logic [W:0]    shifted;
    logic          fits;

    assign shifted = {rem_q[W-1:0], q_q[W2-1]};
    assign fits    = shifted >= {1'b0, dvs_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            q_q   <= '0;
            dvs_q <= '0;
        end else if (load) begin
            rem_q <= '0;
            q_q   <= dvd_mag;
            dvs_q <= dvs_mag;
        end else if (step) begin
            rem_q <= fits ? (shifted - {1'b0, dvs_q}) : shifted;
            q_q   <= {q_q[W2-2:0], fits};
        end
    end

    // R6
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && dvs_q != '0) |=> (rem_q < {1'b0, dvs_q}));

    assign quo = q_q;

endmodule

// File: rtl/mdu_mstep.sv
module mdu_mstep #(
    parameter int W = 32
) (
    input  logic [W-1:0] y_cur,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         n_flag,
    input  logic         v_flag,
    output logic [W-1:0] res,
    output logic [W-1:0] y_next
);

    logic [W-1:0] half;

    assign half   = {n_flag ^ v_flag, a[W-1:1]};
    assign res    = y_cur[0] ? (half + b) : half;
    assign y_next = {a[0], y_cur[W-1:1]};

endmodule

// File: rtl/mdu_y_unit.sv
module mdu_y_unit
    import mdu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [2:0]   op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         flag_n,
    input  logic         flag_v,
    input  logic         y_wr_en,
    input  logic [W-1:0] y_wr_data,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result,
    output logic         ovf,
    output logic         dz,
    output logic [W-1:0] y_q
);

    localparam int W2 = 2 * W;
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

    mdu_state_e state;
    logic       accept, mul_step, div_step, fix_en;
    logic       div_zero;

    assign div_zero = (opb == '0);

    mdu_ctrl #(.W(W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op       (op),
        .div_zero (div_zero),
        .state    (state),
        .busy     (busy),
        .done     (done),
        .accept   (accept),
        .mul_step (mul_step),
        .div_step (div_step),
        .fix_en   (fix_en)
    );

    // operand conditioning
    logic          sgn_mul, sgn_div, neg_in;
    logic [W-1:0]  a_mag, b_mag, dvs_mag;
    logic [W2-1:0] dvd_full, dvd_mag;

    assign sgn_mul  = (op == OP_SMUL);
    assign sgn_div  = (op == OP_SDIV);
    assign a_mag    = (sgn_mul && opa[W-1]) ? -opa : opa;
    assign b_mag    = (sgn_mul && opb[W-1]) ? -opb : opb;
    assign dvd_full = {y_q, opa};
    assign dvd_mag  = (sgn_div && y_q[W-1]) ? -dvd_full : dvd_full;
    assign dvs_mag  = (sgn_div && opb[W-1]) ? -opb : opb;
    assign neg_in   = sgn_mul ? (opa[W-1] ^ opb[W-1]) :
                      sgn_div ? (y_q[W-1] ^ opb[W-1]) : 1'b0;

    logic [W2-1:0] prod, quo;

    mdu_mul_core #(.W(W)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept && op_is_mul(op)),
        .step  (mul_step),
        .a_mag (a_mag),
        .b_mag (b_mag),
        .prod  (prod)
    );

    mdu_div_core #(.W(W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept && op_is_div(op)),
        .step    (div_step),
        .dvd_mag (dvd_mag),
        .dvs_mag (dvs_mag),
        .quo     (quo)
    );

    logic [W-1:0] step_res, step_y;

    mdu_mstep #(.W(W)) u_mstep (
        .y_cur  (y_q),
        .a      (opa),
        .b      (opb),
        .n_flag (flag_n),
        .v_flag (flag_v),
        .res    (step_res),
        .y_next (step_y)
    );

    // captured request attributes
    logic [2:0] op_q;
    logic       neg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= '0;
            neg_q <= 1'b0;
        end else if (accept) begin
            op_q  <= op;
            neg_q <= neg_in;
        end
    end

    // final sign and saturation
    logic [W2-1:0] prod_fix;
    logic [W-1:0]  div_res;
    logic          div_ovf;

    assign prod_fix = neg_q ? -prod : prod;

    always_comb begin
        if (op_q == OP_UDIV) begin
            div_ovf = |quo[W2-1:W];
            div_res = div_ovf ? {W{1'b1}} : quo[W-1:0];
        end else if (!neg_q) begin
            div_ovf = |quo[W2-1:W-1];
            div_res = div_ovf ? MAX_POS : quo[W-1:0];
        end else begin
            div_ovf = (|quo[W2-1:W]) || (quo[W-1] && (|quo[W-2:0]));
            div_res = div_ovf ? MIN_NEG : -quo[W-1:0];
        end
    end

    logic [W-1:0] result_q;
    logic         ovf_q, dz_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            y_q      <= '0;
            ovf_q    <= 1'b0;
            dz_q     <= 1'b0;
        end else if (accept) begin
            ovf_q <= 1'b0;
            dz_q  <= op_is_div(op) && div_zero;
            if (op == OP_MSTEP) begin
                result_q <= step_res;
                y_q      <= step_y;
            end else if (op_is_div(op) && div_zero) begin
                result_q <= '0;
            end
        end else if (fix_en) begin
            if (op_is_mul(op_q)) begin
                result_q <= prod_fix[W-1:0];
                y_q      <= prod_fix[W2-1:W];
            end else begin
                result_q <= div_res;
                ovf_q    <= div_ovf;
            end
        end else if (y_wr_en && !busy && !start) begin
            y_q <= y_wr_data;
        end
    end

    assign result = result_q;
    assign ovf    = done && ovf_q;
    assign dz     = done && dz_q;

    // R13
    y_run_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MULRUN || state == S_DIVRUN) |=> $stable(y_q));

    // R10
    dz_zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dz |-> (result == '0 && !ovf));

    // R9
    sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (result == {W{1'b1}} || result == MAX_POS || result == MIN_NEG));

    // R12
    y_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (y_wr_en && !busy && !start) |=> (y_q == $past(y_wr_data)));

    // R13
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && state != S_FIXUP) |=> $stable(result));

endmodule

// File: tb/mdu_y_unit_tb.sv
`timescale 1ns/1ps
module mdu_y_unit_tb;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [2:0]   op = 3'd0;
    logic [W-1:0] opa = '0, opb = '0;
    logic         flag_n = 1'b0, flag_v = 1'b0;
    logic         y_wr_en = 1'b0;
    logic [W-1:0] y_wr_data = '0;
    logic         busy, done, ovf, dz;
    logic [W-1:0] result, y_q;

    always #4 clk = ~clk;

    mdu_y_unit #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
        .flag_n(flag_n), .flag_v(flag_v), .y_wr_en(y_wr_en), .y_wr_data(y_wr_data),
        .busy(busy), .done(done), .result(result), .ovf(ovf), .dz(dz), .y_q(y_q)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    // reference model state
    bit           m_busy, m_done, m_ovf, m_dz;
    logic [W-1:0] m_res, m_y;
    int           m_left;
    logic [W-1:0] p_res, p_y;
    bit           p_ovf, p_dz;

    task automatic compute(input logic [2:0] c, input logic [W-1:0] a, input logic [W-1:0] b,
                           input bit fn, input bit fv, output int extra);
        logic [63:0] up, uq;
        longint      sp, sd, sq, dv;
        logic [W-1:0] t;
        p_y = m_y; p_ovf = 0; p_dz = 0; p_res = '0;
        case (c)
            3'd0: begin
                up = {32'b0, a} * {32'b0, b};
                p_res = up[31:0]; p_y = up[63:32]; extra = W + 1;
            end
            3'd1: begin
                sp = longint'($signed(a)) * longint'($signed(b));
                up = 64'(sp);
                p_res = up[31:0]; p_y = up[63:32]; extra = W + 1;
            end
            3'd2: begin
                if (b == 0) begin p_dz = 1; extra = 0; end
                else begin
                    uq = {m_y, a} / {32'b0, b};
                    extra = 2 * W + 1;
                    if (uq > 64'hFFFF_FFFF) begin p_ovf = 1; p_res = '1; end
                    else p_res = uq[31:0];
                end
            end
            3'd3: begin
                if (b == 0) begin p_dz = 1; extra = 0; end
                else begin
                    extra = 2 * W + 1;
                    dv = $signed({m_y, a});
                    sd = longint'($signed(b));
                    if (dv == 64'sh8000_0000_0000_0000 && sd == -1) begin
                        p_ovf = 1; p_res = 32'h7FFF_FFFF;
                    end else begin
                        sq = dv / sd;
                        if (sq > 64'sd2147483647) begin p_ovf = 1; p_res = 32'h7FFF_FFFF; end
                        else if (sq < -64'sd2147483648) begin p_ovf = 1; p_res = 32'h8000_0000; end
                        else p_res = sq[31:0];
                    end
                end
            end
            default: begin
                t = {fn ^ fv, a[31:1]};
                p_res = m_y[0] ? t + b : t;
                p_y = {a[0], m_y[31:1]};
                extra = 0;
            end
        endcase
    endtask

    always @(posedge clk or negedge rst_n) begin
        int ex;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_ovf = 0; m_dz = 0; m_res = '0; m_y = '0; m_left = 0;
        end else if (m_busy) begin
            if (m_done) begin
                m_busy = 0; m_done = 0; m_ovf = 0; m_dz = 0;
            end else begin
                m_left--;
                if (m_left == 0) begin
                    m_done = 1; m_res = p_res; m_y = p_y; m_ovf = p_ovf; m_dz = p_dz;
                end
            end
        end else if (start && op <= 3'd4) begin
            compute(op, opa, opb, flag_n, flag_v, ex);
            m_busy = 1; m_left = ex;
            if (ex == 0) begin
                m_done = 1; m_res = p_res; m_y = p_y; m_ovf = p_ovf; m_dz = p_dz;
            end
        end else if (y_wr_en && !start) begin
            m_y = y_wr_data;
        end
    end

    task automatic chk(input bit ok, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy === m_busy, "busy", W'(busy), W'(m_busy));
            chk(done === m_done, "done", W'(done), W'(m_done));
            chk(ovf === m_ovf, "ovf", W'(ovf), W'(m_ovf));
            chk(dz === m_dz, "dz", W'(dz), W'(m_dz));
            chk(result === m_res, "result", result, m_res);
            chk(y_q === m_y, "y", y_q, m_y);
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL R3 watchdog act=%0d exp=<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic issue(input logic [2:0] c, input logic [W-1:0] a, input logic [W-1:0] b,
                         input bit fn = 0, input bit fv = 0);
        @(negedge clk);
        start = 1; op = c; opa = a; opb = b; flag_n = fn; flag_v = fv;
        @(negedge clk);
        start = 0;
        while (m_busy) @(negedge clk);
    endtask

    task automatic wr_y(input logic [W-1:0] v);
        @(negedge clk);
        y_wr_en = 1; y_wr_data = v;
        @(negedge clk);
        y_wr_en = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_req = "R1";
        repeat (2) @(negedge clk);

        cur_req = "R4";
        issue(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        issue(3'd0, 32'd123456, 32'd654321);
        issue(3'd0, 32'd0, 32'hDEAD_BEEF);

        cur_req = "R5";
        issue(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        issue(3'd1, 32'hFFFF_FFFD, 32'd7);
        issue(3'd1, 32'h8000_0000, 32'h8000_0000);
        issue(3'd1, 32'h8000_0000, 32'd1);

        cur_req = "R6";
        wr_y(32'd0); issue(3'd2, 32'd100, 32'd7);
        wr_y(32'd1); issue(3'd2, 32'd0, 32'd2);
        wr_y(32'd2); issue(3'd2, 32'h1234_5678, 32'hFFFF_FFFF);

        cur_req = "R8";
        wr_y(32'd5); issue(3'd2, 32'd0, 32'd3);
        wr_y(32'd3); issue(3'd2, 32'd0, 32'd3);

        cur_req = "R7";
        wr_y(32'hFFFF_FFFF); issue(3'd3, 32'hFFFF_FFF9, 32'd2);
        wr_y(32'd0); issue(3'd3, 32'h8000_0000, 32'hFFFF_FFFF);
        wr_y(32'hFFFF_FFFF); issue(3'd3, 32'h8000_0000, 32'd1);
        wr_y(32'd0); issue(3'd3, 32'd99, 32'hFFFF_FFF6);

        cur_req = "R9";
        wr_y(32'hFFFF_FFFF); issue(3'd3, 32'h8000_0000, 32'hFFFF_FFFF);
        wr_y(32'h8000_0000); issue(3'd3, 32'd0, 32'hFFFF_FFFF);
        wr_y(32'hFFFF_FFFF); issue(3'd3, 32'd0, 32'd1);
        wr_y(32'd0); issue(3'd3, 32'h8000_0000, 32'd1);

        cur_req = "R10";
        wr_y(32'hCAFE_0001); issue(3'd2, 32'd55, 32'd0);
        issue(3'd3, 32'd55, 32'd0);

        cur_req = "R11";
        wr_y(32'hA5A5_A5A5);
        issue(3'd4, 32'h0000_0003, 32'h1111_1111, 1, 0);
        issue(3'd4, 32'h8000_0001, 32'h0F0F_0F0F, 1, 1);
        issue(3'd4, 32'hFFFF_FFFE, 32'h7777_7777, 0, 1);
        for (int k = 0; k < 8; k++) issue(3'd4, $urandom, $urandom, 1'($urandom), 1'($urandom));

        cur_req = "R2";
        issue(3'd5, 32'd9, 32'd9);
        issue(3'd7, 32'd9, 32'd0);
        @(negedge clk); start = 1; op = 3'd0; opa = 32'd11; opb = 32'd13;
        @(negedge clk); op = 3'd4; opa = 32'hFFFF; repeat (5) @(negedge clk);
        start = 0; while (m_busy) @(negedge clk);

        cur_req = "R12";
        @(negedge clk); start = 1; op = 3'd2; opa = 32'd1000; opb = 32'd3;
        y_wr_en = 1; y_wr_data = 32'h5555_0000;
        @(negedge clk); start = 0;
        repeat (10) @(negedge clk);
        y_wr_en = 0; while (m_busy) @(negedge clk);
        @(negedge clk); start = 1; op = 3'd6; y_wr_en = 1; y_wr_data = 32'h1;
        @(negedge clk); start = 0; y_wr_en = 0;
        wr_y(32'h0BAD_F00D);

        cur_req = "R3";
        for (int k = 0; k < 150; k++) begin
            logic [2:0] c;
            logic [W-1:0] b;
            c = 3'($urandom_range(0, 4));
            b = ($urandom_range(0, 9) == 0) ? '0 :
                ($urandom_range(0, 1) ? 32'($urandom_range(1, 40)) : $urandom);
            if (c == 3'd2 || c == 3'd3) begin
                if ($urandom_range(0, 1)) wr_y($urandom);
                else wr_y(32'($urandom_range(0, 3)) - 32'd1);
            end
            issue(c, $urandom, b, 1'($urandom), 1'($urandom));
        end

        cur_req = "R13";
        wr_y(32'd7); issue(3'd2, 32'd1, 32'd9);
        repeat (4) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule